// File: doc/BRIEF.md
# Pause Request Refresh Scheduler

This block decides when flow-control pause frames have to go out on a transmit port. It tracks one link-wide (global) class and eight per-priority classes. A class is active while both its request bit and its enable bit are high. A class that becomes active gets a frame right away. While it stays active, its own countdown timer asks for a fresh frame each time it runs out. When the class is dropped, one last frame carries a zero pause time to release the link partner.

The scheduler does not build frames. It presents a pending descriptor to a downstream frame builder. The descriptor holds a global flag, a priority mask and a per-class zero-time ("quiet") vector. A new descriptor is issued only while the transmit datapath reports no frame in flight. The descriptor is held until the builder returns a one-cycle sent acknowledgement, and that acknowledgement reloads the timers of the classes it covered.

Priority traffic is merged to save link bandwidth. When any priority class needs a frame, every other active priority class that is not already on its way is folded into the same frame. Events that arrive while the scheduler waits for the in-flight frame accumulate into one descriptor. A resend strobe zeroes every timer, so all running classes are refreshed together.

Top module: `pause_refresh_sched`

## Requirements
- R1: After reset no descriptor is pending: `desc_valid_o`, `desc_global_o`, `desc_mask_o` and `desc_quiet_o` are all 0.
- R2: Class i is active only while `req_i[i]` and `en_i[i]` are both 1. A class that turns active is seen by the output two clock edges later as a valid descriptor. A request with its enable low schedules nothing.
- R3: No descriptor is issued while `busy_i` is 1. If work is pending, the descriptor becomes valid on the first edge at which `busy_i` is sampled 0.
- R4: A valid descriptor keeps all its fields unchanged until an edge samples `sent_i` high. That edge clears `desc_valid_o`.
- R5: The acknowledging edge loads the timer of each covered, still-active class with its 16-bit reload value R, found in `reload_i[16*i +: 16]`. The next descriptor for that class becomes valid R+3 cycles after the cycle in which `sent_i` was driven. A reload value of 0 therefore refreshes after 3 cycles.
- R6: A one-cycle pulse on `resend_i` zeroes every timer. Each class whose timer was running then gets a descriptor 3 cycles after the pulse.
- R7: When any priority class needs a frame, every other active priority class that is not in the outstanding descriptor is merged into the same frame. This also stops that class's own timer.
- R8: New requests and expiries that occur while `busy_i` holds off the issue are collected into one descriptor, and no second frame follows it.
- R9: When an active class becomes inactive, its pending frame is cancelled and one release frame is scheduled. In that frame the class's bit is set in both the covering field (`desc_mask_o` bit i, or `desc_global_o` for the global class) and `desc_quiet_o` bit i, which asks for a zero pause time.
- R10: Bit 8 of the class vectors is the global class. A global descriptor has `desc_global_o` = 1 and `desc_mask_o` = 0. When global and priority work are pending together, the global work is issued first.
- R11: Bit i of `desc_mask_o` (i = 0..7) stands for priority class i. A valid descriptor always covers at least one class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 9 | Pause request per class; bit 8 = global, bits 7:0 = priorities |
| en_i | input | 9 | Pause enable per class, same bit order |
| reload_i | input | 144 | Refresh reload values, 16 bits per class, class i at [16*i +: 16] |
| resend_i | input | 1 | One-cycle strobe that zeroes all timers |
| busy_i | input | 1 | A frame is in flight on the transmit datapath |
| sent_i | input | 1 | One-cycle acknowledgement that the descriptor's frame was sent |
| desc_valid_o | output | 1 | A descriptor is pending |
| desc_global_o | output | 1 | The descriptor is a global pause frame |
| desc_mask_o | output | 8 | Priority classes covered by the descriptor |
| desc_quiet_o | output | 9 | Per class: send a zero pause time (release) |

## Verification
The checker watches the descriptor handshake on every cycle. It confirms that a pending descriptor holds still until it is acknowledged and that the acknowledgement clears it. It also confirms that nothing is issued while the datapath is busy, that a global descriptor carries no priority bits, and that release bits stay inside the covered set. The timing of timer refreshes, the merging of priority classes, the collection of events during a busy stretch, the resend strobe and the release frames all depend on stimulus history. Only the bench's directed scenarios can show these, and they do so by measuring latencies and comparing the masks.

// File: rtl/pause_sched_pkg.sv
package pause_sched_pkg;
  // Default class layout: eight priority classes plus one global class on top.
  localparam int unsigned DEF_PRI_N = 8;
  localparam int unsigned DEF_TMR_W = 16;

  function automatic int unsigned cls_count(input int unsigned pri_n);
    return pri_n + 1;
  endfunction
endpackage

// File: rtl/pause_rst_sync.sv
module pause_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/pause_class_timer.sv
module pause_class_timer #(
  parameter int unsigned TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [TMR_W-1:0] reload_i,
  input  logic             stop_i,
  input  logic             zero_i,
  output logic             expire_o,
  output logic             armed_o
);
  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             cnt_en;

  // A load beats a stop, a stop beats the resend zeroing, which beats counting.
  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (load_i) begin
      cnt_d   = reload_i;
      armed_d = 1'b1;
    end else if (stop_i) begin
      armed_d = 1'b0;
    end else if (zero_i) begin
      cnt_d = '0;
    end else if (armed_q && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  assign cnt_en = load_i | stop_i | zero_i | armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign expire_o = armed_q && (cnt_q == '0);
  assign armed_o  = armed_q;
endmodule

// File: rtl/pause_pend_tracker.sv
module pause_pend_tracker #(
  parameter int unsigned PRI_N = 8,
  localparam int unsigned CLS_N = PRI_N + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CLS_N-1:0] req_i,
  input  logic [CLS_N-1:0] en_i,
  input  logic [CLS_N-1:0] expire_i,
  input  logic             issue_i,
  input  logic [CLS_N-1:0] cap_i,
  input  logic [CLS_N-1:0] blocked_i,
  output logic [CLS_N-1:0] act_o,
  output logic [CLS_N-1:0] pend_o,
  output logic [CLS_N-1:0] quiet_o,
  output logic [CLS_N-1:0] pend_next_o
);
  logic [CLS_N-1:0] act, act_q;
  logic [CLS_N-1:0] rise, fall;
  logic [CLS_N-1:0] pend_q, pend_d;
  logic [CLS_N-1:0] quiet_q, quiet_d;
  logic [PRI_N-1:0] pri_pull;

  assign act  = req_i & en_i;
  assign rise = act & ~act_q;
  assign fall = ~act & act_q;

  always_comb begin
    pend_d  = pend_q;
    quiet_d = quiet_q;
    for (int i = 0; i < CLS_N; i++) begin
      if (issue_i && cap_i[i]) begin
        pend_d[i]  = 1'b0;
        quiet_d[i] = 1'b0;
      end
      if (rise[i]) begin
        pend_d[i]  = 1'b1;
        quiet_d[i] = 1'b0;
      end
      if (expire_i[i] && act[i]) pend_d[i] = 1'b1;
      if (fall[i]) begin
        pend_d[i]  = 1'b0;
        quiet_d[i] = 1'b1;
      end
    end
    // Priority merge: one needy priority drags every free active priority along.
    pri_pull = act[PRI_N-1:0] & ~blocked_i[PRI_N-1:0];
    if (|pend_d[PRI_N-1:0]) pend_d[PRI_N-1:0] = pend_d[PRI_N-1:0] | pri_pull;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= '0;
      pend_q  <= '0;
      quiet_q <= '0;
    end else begin
      act_q   <= act;
      pend_q  <= pend_d;
      quiet_q <= quiet_d;
    end
  end

  assign act_o       = act;
  assign pend_o      = pend_q;
  assign quiet_o     = quiet_q;
  assign pend_next_o = pend_d;
endmodule

// File: rtl/pause_desc_issuer.sv
module pause_desc_issuer #(
  parameter int unsigned PRI_N = 8,
  localparam int unsigned CLS_N = PRI_N + 1,
  localparam int unsigned GLB   = PRI_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CLS_N-1:0] pend_i,
  input  logic [CLS_N-1:0] quiet_i,
  input  logic             busy_i,
  input  logic             sent_i,
  output logic             issue_o,
  output logic [CLS_N-1:0] cap_o,
  output logic [CLS_N-1:0] blocked_o,
  output logic [CLS_N-1:0] load_o,
  output logic             valid_o,
  output logic [CLS_N-1:0] cls_o,
  output logic [CLS_N-1:0] zero_o
);
  logic [CLS_N-1:0] work;
  logic [CLS_N-1:0] cls_q, cls_d;
  logic [CLS_N-1:0] zero_q, zero_d;
  logic             valid_q, valid_d;
  logic             ack;

  assign work    = pend_i | quiet_i;
  assign issue_o = !valid_q && !busy_i && (|work);
  assign ack     = valid_q && sent_i;

  // Global work goes alone and first; otherwise take every needy priority.
  always_comb begin
    cap_o = '0;
    if (work[GLB]) cap_o[GLB] = 1'b1;
    else           cap_o[PRI_N-1:0] = work[PRI_N-1:0];
  end

  always_comb begin
    valid_d = valid_q;
    cls_d   = cls_q;
    zero_d  = zero_q;
    if (issue_o) begin
      valid_d = 1'b1;
      cls_d   = cap_o;
      zero_d  = cap_o & quiet_i;
    end else if (ack) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cls_q   <= '0;
      zero_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (issue_o) begin
        cls_q  <= cls_d;
        zero_q <= zero_d;
      end
    end
  end

  assign blocked_o = issue_o ? cap_o : (valid_q ? cls_q : '0);
  assign load_o    = ack ? cls_q : '0;
  assign valid_o   = valid_q;
  assign cls_o     = valid_q ? cls_q : '0;
  assign zero_o    = valid_q ? zero_q : '0;
endmodule

// File: rtl/pause_refresh_sched.sv
module pause_refresh_sched
  import pause_sched_pkg::*;
#(
  parameter int unsigned PRI_N = DEF_PRI_N,
  parameter int unsigned TMR_W = DEF_TMR_W,
  localparam int unsigned CLS_N = PRI_N + 1,
  localparam int unsigned GLB   = PRI_N
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CLS_N-1:0]       req_i,
  input  logic [CLS_N-1:0]       en_i,
  input  logic [CLS_N*TMR_W-1:0] reload_i,
  input  logic                   resend_i,
  input  logic                   busy_i,
  input  logic                   sent_i,
  output logic                   desc_valid_o,
  output logic                   desc_global_o,
  output logic [PRI_N-1:0]       desc_mask_o,
  output logic [CLS_N-1:0]       desc_quiet_o
);
  logic             srst_n;
  logic [CLS_N-1:0] act, pend, quiet, pend_next;
  logic [CLS_N-1:0] expire, armed;
  logic [CLS_N-1:0] cap, blocked, load, cls;
  logic             issue;

  pause_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  pause_pend_tracker #(.PRI_N(PRI_N)) u_track (
    .clk         (clk),
    .rst_n       (srst_n),
    .req_i       (req_i),
    .en_i        (en_i),
    .expire_i    (expire),
    .issue_i     (issue),
    .cap_i       (cap),
    .blocked_i   (blocked),
    .act_o       (act),
    .pend_o      (pend),
    .quiet_o     (quiet),
    .pend_next_o (pend_next)
  );

  pause_desc_issuer #(.PRI_N(PRI_N)) u_issue (
    .clk       (clk),
    .rst_n     (srst_n),
    .pend_i    (pend),
    .quiet_i   (quiet),
    .busy_i    (busy_i),
    .sent_i    (sent_i),
    .issue_o   (issue),
    .cap_o     (cap),
    .blocked_o (blocked),
    .load_o    (load),
    .valid_o   (desc_valid_o),
    .cls_o     (cls),
    .zero_o    (desc_quiet_o)
  );

  for (genvar g = 0; g < CLS_N; g++) begin : g_tmr
    pause_class_timer #(.TMR_W(TMR_W)) u_tmr (
      .clk      (clk),
      .rst_n    (srst_n),
      .load_i   (load[g] & act[g]),
      .reload_i (reload_i[g*TMR_W +: TMR_W]),
      .stop_i   (pend_next[g] | ~act[g]),
      .zero_i   (resend_i),
      .expire_o (expire[g]),
      .armed_o  (armed[g])
    );
  end

  assign desc_global_o = cls[GLB];
  assign desc_mask_o   = cls[PRI_N-1:0];

  // Armed state is internal bookkeeping of the timers; keep it observable for the checker.
  logic any_armed;
  assign any_armed = |armed;
endmodule

// File: rtl/pause_refresh_sched_chk.sv
module pause_refresh_sched_chk #(
  parameter int unsigned PRI_N = 8,
  localparam int unsigned CLS_N = PRI_N + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_i,
  input logic             sent_i,
  input logic             desc_valid_o,
  input logic             desc_global_o,
  input logic [PRI_N-1:0] desc_mask_o,
  input logic [CLS_N-1:0] desc_quiet_o,
  input logic             any_armed
);
  // R4: a pending descriptor does not move until acknowledged
  p_desc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid_o && !sent_i) |=> (desc_valid_o && $stable(desc_global_o)
      && $stable(desc_mask_o) && $stable(desc_quiet_o)));

  // R4: the acknowledging edge retires the descriptor
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid_o && sent_i) |=> !desc_valid_o);

  // R3: nothing new appears while the datapath is busy
  p_no_issue_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!desc_valid_o && busy_i) |=> !desc_valid_o);

  // R10: a global frame carries no priority bits
  p_global_alone_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid_o && desc_global_o) |-> ((desc_mask_o == '0) && (desc_quiet_o[PRI_N-1:0] == '0)));

  // R11: a valid descriptor covers at least one class
  p_nonempty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid_o |-> (desc_global_o || (desc_mask_o != '0)));

  // R9: release bits stay inside the covered priority set
  p_quiet_in_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid_o && !desc_global_o) |-> ((desc_quiet_o[PRI_N-1:0] & ~desc_mask_o) == '0));

  // R1: an idle output stays fully cleared
  p_idle_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !desc_valid_o |-> (!desc_global_o && (desc_mask_o == '0) && (desc_quiet_o == '0)));

  logic unused_ok;
  assign unused_ok = any_armed;
endmodule

bind pause_refresh_sched pause_refresh_sched_chk #(.PRI_N(PRI_N)) u_chk (
  .clk           (clk),
  .rst_n         (srst_n),
  .busy_i        (busy_i),
  .sent_i        (sent_i),
  .desc_valid_o  (desc_valid_o),
  .desc_global_o (desc_global_o),
  .desc_mask_o   (desc_mask_o),
  .desc_quiet_o  (desc_quiet_o),
  .any_armed     (any_armed)
);

// File: tb/pause_refresh_sched_tb.sv
`timescale 1ns/1ps
module pause_refresh_sched_tb;
  localparam int unsigned PN = 8;
  localparam int unsigned CN = PN + 1;
  localparam int unsigned TW = 16;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [CN-1:0]   req, en;
  logic [CN*TW-1:0] reload;
  logic            resend, busy, sent;
  logic            d_valid, d_global;
  logic [PN-1:0]   d_mask;
  logic [CN-1:0]   d_quiet;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  pause_refresh_sched u_dut (
    .clk (clk), .rst_n (rst_n), .req_i (req), .en_i (en), .reload_i (reload),
    .resend_i (resend), .busy_i (busy), .sent_i (sent),
    .desc_valid_o (d_valid), .desc_global_o (d_global),
    .desc_mask_o (d_mask), .desc_quiet_o (d_quiet)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic set_reload(input int cls, input int val);
    reload[cls*TW +: TW] = val[TW-1:0];
  endtask

  task automatic ack();
    sent = 1'b1;
    @(negedge clk);
    sent = 1'b0;
  endtask

  task automatic wait_desc(input int maxc, output int n);
    n = 0;
    while (!d_valid && n < maxc) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic ack_timed(input int maxc, output int n);
    sent = 1'b1;
    @(negedge clk);
    sent = 1'b0;
    n = 1;
    while (!d_valid && n < maxc) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic drain();
    req = '0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (d_valid) ack();
    end
  endtask

  task automatic t_reset();
    chk("R1 valid", d_valid, 0);
    chk("R1 global", d_global, 0);
    chk("R1 mask", d_mask, 0);
    chk("R1 quiet", d_quiet, 0);
  endtask

  task automatic t_single_and_release();
    int n;
    req[2] = 1'b1;
    wait_desc(20, n);
    chk("R2 latency", n, 2);
    chk("R11 mask bit2", d_mask, 32'h04);
    chk("R11 quiet", d_quiet, 0);
    ack();
    req[2] = 1'b0;
    wait_desc(20, n);
    chk("R9 release latency", n, 2);
    chk("R9 release mask", d_mask, 32'h04);
    chk("R9 release quiet", d_quiet, 32'h004);
    ack();
    drain();
  endtask

  task automatic t_enable_gate();
    int n;
    en[5]  = 1'b0;
    req[5] = 1'b1;
    repeat (6) @(negedge clk);
    chk("R2 gated no desc", d_valid, 0);
    en[5] = 1'b1;
    wait_desc(20, n);
    chk("R2 enable latency", n, 2);
    chk("R2 enable mask", d_mask, 32'h20);
    ack();
    drain();
  endtask

  task automatic t_busy();
    int n;
    busy   = 1'b1;
    req[1] = 1'b1;
    repeat (10) @(negedge clk);
    chk("R3 held by busy", d_valid, 0);
    busy = 1'b0;
    wait_desc(20, n);
    chk("R3 issue after busy", n, 1);
    chk("R3 mask", d_mask, 32'h02);
    ack();
    drain();
  endtask

  task automatic t_hold();
    int n;
    req[0] = 1'b1;
    wait_desc(20, n);
    repeat (10) @(negedge clk);
    chk("R4 still valid", d_valid, 1);
    chk("R4 mask stable", d_mask, 32'h01);
    chk("R4 global stable", d_global, 0);
    ack();
    chk("R4 cleared by ack", d_valid, 0);
    drain();
  endtask

  task automatic t_refresh();
    int n;
    set_reload(3, 5);
    req[3] = 1'b1;
    wait_desc(20, n);
    ack_timed(50, n);
    chk("R5 refresh reload5", n, 8);
    chk("R5 refresh mask", d_mask, 32'h08);
    set_reload(3, 0);
    ack_timed(50, n);
    chk("R5 refresh reload0", n, 3);
    set_reload(3, 1000);
    ack();
    drain();
  endtask

  task automatic t_resend();
    int n;
    req[4] = 1'b1;
    wait_desc(20, n);
    ack();
    repeat (5) @(negedge clk);
    chk("R6 quiet before strobe", d_valid, 0);
    resend = 1'b1;
    @(negedge clk);
    resend = 1'b0;
    n = 1;
    while (!d_valid && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk("R6 resend latency", n, 3);
    chk("R6 resend mask", d_mask, 32'h10);
    ack();
    drain();
  endtask

  task automatic t_merge();
    int n;
    set_reload(1, 20);
    req[1] = 1'b1;
    req[6] = 1'b1;
    wait_desc(20, n);
    chk("R7 first mask", d_mask, 32'h42);
    ack_timed(60, n);
    chk("R7 merged latency", n, 23);
    chk("R7 merged mask", d_mask, 32'h42);
    set_reload(1, 1000);
    ack();
    drain();
  endtask

  task automatic t_wait_merge();
    int n;
    busy   = 1'b1;
    req[0] = 1'b1;
    repeat (3) @(negedge clk);
    req[7] = 1'b1;
    repeat (3) @(negedge clk);
    busy = 1'b0;
    wait_desc(20, n);
    chk("R8 one desc mask", d_mask, 32'h81);
    ack();
    repeat (5) @(negedge clk);
    chk("R8 no second frame", d_valid, 0);
    drain();
  endtask

  task automatic t_global();
    int n;
    req[8] = 1'b1;
    wait_desc(20, n);
    chk("R10 global flag", d_global, 1);
    chk("R10 global mask", d_mask, 0);
    chk("R10 global quiet", d_quiet, 0);
    ack();
    req[8] = 1'b0;
    wait_desc(20, n);
    chk("R10 global release flag", d_global, 1);
    chk("R9 global release quiet", d_quiet, 32'h100);
    ack();
    drain();
  endtask

  initial begin
    rst_n  = 1'b0;
    req    = '0;
    en     = '1;
    resend = 1'b0;
    busy   = 1'b0;
    sent   = 1'b0;
    for (int c = 0; c < CN; c++) reload[c*TW +: TW] = 16'd1000;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_single_and_release();
    t_enable_gate();
    t_busy();
    t_hold();
    t_refresh();
    t_resend();
    t_merge();
    t_wait_merge();
    t_global();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule